// File: doc/BRIEF.md
# Cache Line Word Tracker

This block holds per-line bookkeeping for a cache that fetches only selected words of each line. For every line it stores the code context of the instruction that caused the line to be brought in, the word offset that started the miss, a vector of words that are present, and a vector of words that have been referenced. A fill event installs a line, an access event looks up one word of a line, and an eviction request reads the line's history out so that a word-usage predictor can learn from it.

Demand fills record their context and offset at once. Prefetched lines arrive without context; the first demand access to such a line supplies the context and offset. A prefetched line that is evicted before anyone touched it sends nothing to the predictor, so untouched prefetches never train it. The caller presents the context as the upper bits of the PC; it owns the tag array, the data storage and the choice of victim.

All three request kinds may arrive together, one of each per cycle. Access responses and eviction records appear one cycle after the request.

Top module: `line_word_tracker`

## Requirements
- R1: After reset every line is empty: no output strobe is high, and an access to any word of any line reports a word miss.
- R2: A demand fill (prefetch flag low) marks exactly the words of its mask as present, clears the used vector, and records the given context and word offset in the line.
- R3: An access to a word whose present bit is set raises accPresent (with accDone) in the next cycle and sets that word's used bit; bit i of every word vector stands for word offset i.
- R4: An access to a word whose present bit is clear raises accWordMiss (with accDone) in the next cycle and leaves the used vector unchanged.
- R5: Evicting a line that holds a context raises updValid in the next cycle with that line's context, initiating offset and used vector, and leaves the line empty.
- R6: A prefetch fill (prefetch flag high) marks the masked words present but stores no context; if the line is evicted before any demand access, no update is issued.
- R7: The first demand access to a prefetched line, hit or word miss, records that access's context and offset in the line and clears its prefetched state; later accesses do not change them, and a later eviction issues an update carrying them.
- R8: Reads for an access or an eviction see the line as it was before the cycle's writes; when requests name the same line in one cycle, the fill's write wins over the eviction's clear, which wins over the access's update.
- R9: Evicting a line that is empty issues no update.
- R10: A fill of a line that already holds data replaces all of its state, so an earlier used vector does not survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fillValid | input | 1 | Fill request strobe |
| fillLine | input | IDX_W | Line being filled |
| fillPcHi | input | CTX_W | Upper PC bits of the missing instruction (context) |
| fillOffset | input | OFF_W | Word offset that started the miss |
| fillMask | input | WORDS | Words delivered by the fill |
| fillPrefetch | input | 1 | Fill is a prefetch |
| accValid | input | 1 | Demand access strobe |
| accLine | input | IDX_W | Line accessed |
| accOffset | input | OFF_W | Word accessed |
| accPcHi | input | CTX_W | Upper PC bits of the accessing instruction |
| evictValid | input | 1 | Eviction request strobe |
| evictLine | input | IDX_W | Line evicted |
| accDone | output | 1 | Access response valid |
| accPresent | output | 1 | Accessed word was present |
| accWordMiss | output | 1 | Accessed word was absent |
| updValid | output | 1 | Predictor update record valid |
| updCtx | output | CTX_W | Context of the evicted line |
| updOffset | output | OFF_W | Initiating word offset of the evicted line |
| updUsed | output | WORDS | Used-word vector of the evicted line |

## Verification
The bench aims at prefetched lines: evicted untouched, touched first on an absent word, and touched twice with different contexts; a design that let untouched prefetches train the predictor would emit a spurious updValid, and one that re-captured context on every access would report the second context. It drives fill, access and eviction on the same line in one cycle, where a wrong read timing shows up as a response or record built from the new line rather than the old one. Refills of used lines and accesses to absent words catch a used vector that is not cleared or that wrongly gains bits.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

  // Write strobes the control hands to the datapath each cycle.
  typedef struct packed {
    logic fillEn;     // install a line
    logic fillPf;     // the install is a prefetch
    logic accMark;    // set the used bit of the accessed word
    logic accCapture; // first touch of a prefetched line: take context
    logic evictClear; // empty the evicted line
    logic evictEmit;  // latch an update record
  } lwtStrobe_t;

endpackage

// File: rtl/lwt_line_slot.sv
module lwt_line_slot #(
  parameter int WORDS = 4,
  parameter int CTX_W = 6,
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillHit,
  input  logic             fillPf,
  input  logic [CTX_W-1:0] fillCtx,
  input  logic [OFF_W-1:0] fillOffset,
  input  logic [WORDS-1:0] fillMask,
  input  logic             evictHit,
  input  logic             accHit,
  input  logic             accMark,
  input  logic             accCapture,
  input  logic [CTX_W-1:0] accCtx,
  input  logic [OFF_W-1:0] accOffset,
  input  logic [WORDS-1:0] accOneHot,
  output logic [CTX_W-1:0] ctxQ,
  output logic [OFF_W-1:0] offQ,
  output logic [WORDS-1:0] presentQ,
  output logic [WORDS-1:0] usedQ,
  output logic             ctxValidQ,
  output logic             pfQ
);

  // Priority: fill, then eviction clear, then access update.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctxQ      <= '0;
      offQ      <= '0;
      presentQ  <= '0;
      usedQ     <= '0;
      ctxValidQ <= 1'b0;
      pfQ       <= 1'b0;
    end else if (fillHit) begin
      ctxQ      <= fillPf ? '0 : fillCtx;
      offQ      <= fillPf ? '0 : fillOffset;
      presentQ  <= fillMask;
      usedQ     <= '0;
      ctxValidQ <= !fillPf;
      pfQ       <= fillPf;
    end else if (evictHit) begin
      ctxQ      <= '0;
      offQ      <= '0;
      presentQ  <= '0;
      usedQ     <= '0;
      ctxValidQ <= 1'b0;
      pfQ       <= 1'b0;
    end else if (accHit) begin
      if (accMark) begin
        usedQ <= usedQ | accOneHot;
      end
      if (accCapture) begin
        ctxQ      <= accCtx;
        offQ      <= accOffset;
        ctxValidQ <= 1'b1;
        pfQ       <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lwt_datapath.sv
module lwt_datapath
  import lwt_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int WORDS     = 4,
  parameter int CTX_W     = 6,
  parameter int IDX_W     = 4,
  parameter int OFF_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  lwtStrobe_t       strobe,
  input  logic [IDX_W-1:0] fillLine,
  input  logic [CTX_W-1:0] fillPcHi,
  input  logic [OFF_W-1:0] fillOffset,
  input  logic [WORDS-1:0] fillMask,
  input  logic [IDX_W-1:0] accLine,
  input  logic [OFF_W-1:0] accOffset,
  input  logic [CTX_W-1:0] accPcHi,
  input  logic [IDX_W-1:0] evictLine,
  output logic             accWordPresent,
  output logic             accLinePf,
  output logic             evictCtxValid,
  output logic [CTX_W-1:0] updCtx,
  output logic [OFF_W-1:0] updOffset,
  output logic [WORDS-1:0] updUsed
);

  logic [NUM_LINES-1:0][CTX_W-1:0] ctxAll;
  logic [NUM_LINES-1:0][OFF_W-1:0] offAll;
  logic [NUM_LINES-1:0][WORDS-1:0] presentAll;
  logic [NUM_LINES-1:0][WORDS-1:0] usedAll;
  logic [NUM_LINES-1:0]            ctxValidAll;
  logic [NUM_LINES-1:0]            pfAll;
  logic [WORDS-1:0]                accOneHot;

  assign accOneHot = WORDS'(1) << accOffset;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gSlot
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    lwt_line_slot #(.WORDS(WORDS), .CTX_W(CTX_W), .OFF_W(OFF_W)) i_slot (
      .clk        (clk),
      .rstN       (rstN),
      .fillHit    (strobe.fillEn && (fillLine == MY_IDX)),
      .fillPf     (strobe.fillPf),
      .fillCtx    (fillPcHi),
      .fillOffset (fillOffset),
      .fillMask   (fillMask),
      .evictHit   (strobe.evictClear && (evictLine == MY_IDX)),
      .accHit     (accLine == MY_IDX),
      .accMark    (strobe.accMark),
      .accCapture (strobe.accCapture),
      .accCtx     (accPcHi),
      .accOffset  (accOffset),
      .accOneHot  (accOneHot),
      .ctxQ       (ctxAll[g]),
      .offQ       (offAll[g]),
      .presentQ   (presentAll[g]),
      .usedQ      (usedAll[g]),
      .ctxValidQ  (ctxValidAll[g]),
      .pfQ        (pfAll[g])
    );
  end

  // Read ports see the state before this cycle's writes.
  assign accWordPresent = presentAll[accLine][accOffset];
  assign accLinePf      = pfAll[accLine];
  assign evictCtxValid  = ctxValidAll[evictLine];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updCtx    <= '0;
      updOffset <= '0;
      updUsed   <= '0;
    end else if (strobe.evictEmit) begin
      updCtx    <= ctxAll[evictLine];
      updOffset <= offAll[evictLine];
      updUsed   <= usedAll[evictLine];
    end
  end

endmodule

// File: rtl/lwt_ctrl.sv
module lwt_ctrl
  import lwt_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillValid,
  input  logic             fillPrefetch,
  input  logic [IDX_W-1:0] fillLine,
  input  logic             accValid,
  input  logic [IDX_W-1:0] accLine,
  input  logic             accWordPresent,
  input  logic             accLinePf,
  input  logic             evictValid,
  input  logic [IDX_W-1:0] evictLine,
  input  logic             evictCtxValid,
  output lwtStrobe_t       strobe,
  output logic             accDone,
  output logic             accPresent,
  output logic             accWordMiss,
  output logic             updValid
);

  logic accOverridden;
  logic evictOverridden;

  assign accOverridden   = (fillValid && (fillLine == accLine)) ||
                           (evictValid && (evictLine == accLine));
  assign evictOverridden = fillValid && (fillLine == evictLine);

  always_comb begin
    strobe            = '0;
    strobe.fillEn     = fillValid;
    strobe.fillPf     = fillPrefetch;
    strobe.accMark    = accValid && accWordPresent && !accOverridden;
    strobe.accCapture = accValid && accLinePf && !accOverridden;
    strobe.evictClear = evictValid && !evictOverridden;
    strobe.evictEmit  = evictValid && evictCtxValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accDone     <= 1'b0;
      accPresent  <= 1'b0;
      accWordMiss <= 1'b0;
      updValid    <= 1'b0;
    end else begin
      accDone     <= accValid;
      accPresent  <= accValid && accWordPresent;
      accWordMiss <= accValid && !accWordPresent;
      updValid    <= strobe.evictEmit;
    end
  end

endmodule

// File: rtl/line_word_tracker.sv
module line_word_tracker
  import lwt_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int WORDS     = 4,
  parameter int CTX_W     = 6,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int OFF_W    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillValid,
  input  logic [IDX_W-1:0] fillLine,
  input  logic [CTX_W-1:0] fillPcHi,
  input  logic [OFF_W-1:0] fillOffset,
  input  logic [WORDS-1:0] fillMask,
  input  logic             fillPrefetch,
  input  logic             accValid,
  input  logic [IDX_W-1:0] accLine,
  input  logic [OFF_W-1:0] accOffset,
  input  logic [CTX_W-1:0] accPcHi,
  input  logic             evictValid,
  input  logic [IDX_W-1:0] evictLine,
  output logic             accDone,
  output logic             accPresent,
  output logic             accWordMiss,
  output logic             updValid,
  output logic [CTX_W-1:0] updCtx,
  output logic [OFF_W-1:0] updOffset,
  output logic [WORDS-1:0] updUsed
);

  lwtStrobe_t strobe;
  logic       accWordPresent;
  logic       accLinePf;
  logic       evictCtxValid;

  lwt_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .fillValid      (fillValid),
    .fillPrefetch   (fillPrefetch),
    .fillLine       (fillLine),
    .accValid       (accValid),
    .accLine        (accLine),
    .accWordPresent (accWordPresent),
    .accLinePf      (accLinePf),
    .evictValid     (evictValid),
    .evictLine      (evictLine),
    .evictCtxValid  (evictCtxValid),
    .strobe         (strobe),
    .accDone        (accDone),
    .accPresent     (accPresent),
    .accWordMiss    (accWordMiss),
    .updValid       (updValid)
  );

  lwt_datapath #(
    .NUM_LINES(NUM_LINES), .WORDS(WORDS), .CTX_W(CTX_W),
    .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) i_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .fillLine       (fillLine),
    .fillPcHi       (fillPcHi),
    .fillOffset     (fillOffset),
    .fillMask       (fillMask),
    .accLine        (accLine),
    .accOffset      (accOffset),
    .accPcHi        (accPcHi),
    .evictLine      (evictLine),
    .accWordPresent (accWordPresent),
    .accLinePf      (accLinePf),
    .evictCtxValid  (evictCtxValid),
    .updCtx         (updCtx),
    .updOffset      (updOffset),
    .updUsed        (updUsed)
  );

endmodule

// File: rtl/lwt_checker.sv
module lwt_checker (
  input logic clk,
  input logic rstN,
  input logic accValid,
  input logic accWordPresent,
  input logic accPresent,
  input logic accWordMiss,
  input logic evictValid,
  input logic evictCtxValid,
  input logic updValid
);

  assert_hit_reported_R3: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accWordPresent |=> accPresent && !accWordMiss);

  assert_absent_reported_R4: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !accWordPresent |=> accWordMiss && !accPresent);

  assert_record_issued_R5: assert property (@(posedge clk) disable iff (!rstN)
    evictValid && evictCtxValid |=> updValid);

  assert_no_record_without_ctx_R6: assert property (@(posedge clk) disable iff (!rstN)
    evictValid && !evictCtxValid |=> !updValid);

  assert_record_needs_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> $past(evictValid));

endmodule

bind line_word_tracker lwt_checker i_lwt_checker (
  .clk            (clk),
  .rstN           (rstN),
  .accValid       (accValid),
  .accWordPresent (accWordPresent),
  .accPresent     (accPresent),
  .accWordMiss    (accWordMiss),
  .evictValid     (evictValid),
  .evictCtxValid  (evictCtxValid),
  .updValid       (updValid)
);

// File: tb/test_line_word_tracker.sv
`timescale 1ns/1ps
module test_line_word_tracker;

  localparam int NL = 16;
  localparam int NW = 4;
  localparam int CW = 6;
  localparam int IW = 4;
  localparam int OW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fillValid = 1'b0;
  logic [IW-1:0] fillLine = '0;
  logic [CW-1:0] fillPcHi = '0;
  logic [OW-1:0] fillOffset = '0;
  logic [NW-1:0] fillMask = '0;
  logic          fillPrefetch = 1'b0;
  logic          accValid = 1'b0;
  logic [IW-1:0] accLine = '0;
  logic [OW-1:0] accOffset = '0;
  logic [CW-1:0] accPcHi = '0;
  logic          evictValid = 1'b0;
  logic [IW-1:0] evictLine = '0;
  logic          accDone, accPresent, accWordMiss, updValid;
  logic [CW-1:0] updCtx;
  logic [OW-1:0] updOffset;
  logic [NW-1:0] updUsed;

  always #2 clk = ~clk;

  line_word_tracker #(.NUM_LINES(NL), .WORDS(NW), .CTX_W(CW)) i_line_word_tracker (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .fillLine(fillLine), .fillPcHi(fillPcHi),
    .fillOffset(fillOffset), .fillMask(fillMask), .fillPrefetch(fillPrefetch),
    .accValid(accValid), .accLine(accLine), .accOffset(accOffset), .accPcHi(accPcHi),
    .evictValid(evictValid), .evictLine(evictLine),
    .accDone(accDone), .accPresent(accPresent), .accWordMiss(accWordMiss),
    .updValid(updValid), .updCtx(updCtx), .updOffset(updOffset), .updUsed(updUsed)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Behavioural model: one entry per line.
  int mHasCtx [NL];
  int mPf     [NL];
  int mCtx    [NL];
  int mOff    [NL];
  int mPres   [NL];
  int mUsed   [NL];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: drive requests, predict, advance, compare.
  task automatic cyc(input bit fv, input int fl, input int fctx, input int foff,
                     input int fmask, input bit fpf,
                     input bit av, input int al, input int aoff, input int actx,
                     input bit ev, input int el, input string tag);
    int eDone, ePres, eMiss, eUpd, eCtx, eOff, eUsed;
    fillValid = fv; fillLine = IW'(fl); fillPcHi = CW'(fctx); fillOffset = OW'(foff);
    fillMask = NW'(fmask); fillPrefetch = fpf;
    accValid = av; accLine = IW'(al); accOffset = OW'(aoff); accPcHi = CW'(actx);
    evictValid = ev; evictLine = IW'(el);
    eDone = av;
    ePres = av && ((mPres[al] >> aoff) & 1);
    eMiss = av && !ePres;
    eUpd  = ev && mHasCtx[el];
    eCtx = mCtx[el]; eOff = mOff[el]; eUsed = mUsed[el];
    // Later writes override earlier ones on the same line.
    if (av) begin
      if ((mPres[al] >> aoff) & 1) mUsed[al] |= (1 << aoff);
      if (mPf[al]) begin
        mPf[al] = 0; mHasCtx[al] = 1; mCtx[al] = actx; mOff[al] = aoff;
      end
    end
    if (ev) begin
      mHasCtx[el] = 0; mPf[el] = 0; mCtx[el] = 0; mOff[el] = 0; mPres[el] = 0; mUsed[el] = 0;
    end
    if (fv) begin
      mHasCtx[fl] = !fpf; mPf[fl] = fpf; mCtx[fl] = fpf ? 0 : fctx;
      mOff[fl] = fpf ? 0 : foff; mPres[fl] = fmask; mUsed[fl] = 0;
    end
    @(posedge clk);
    #1;
    chk(tag, "accDone", int'(accDone), eDone);
    chk(tag, "accPresent", int'(accPresent), ePres);
    chk(tag, "accWordMiss", int'(accWordMiss), eMiss);
    chk(tag, "updValid", int'(updValid), eUpd);
    if (eUpd) begin
      chk(tag, "updCtx", int'(updCtx), eCtx);
      chk(tag, "updOffset", int'(updOffset), eOff);
      chk(tag, "updUsed", int'(updUsed), eUsed);
    end
  endtask

  task automatic fill(input int l, input int ctx, input int off, input int mask,
                      input bit pf, input string tag);
    cyc(1, l, ctx, off, mask, pf, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic access(input int l, input int off, input int ctx, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 1, l, off, ctx, 0, 0, tag);
  endtask

  task automatic evict(input int l, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, l, tag);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      mHasCtx[i] = 0; mPf[i] = 0; mCtx[i] = 0; mOff[i] = 0; mPres[i] = 0; mUsed[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs idle in reset and right after.
    chk("R1", "accDone in reset", int'(accDone), 0);
    chk("R1", "updValid in reset", int'(updValid), 0);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "accDone after reset", int'(accDone), 0);
    chk("R1", "updValid after reset", int'(updValid), 0);
    for (int l = 0; l < NL; l += 5) access(l, l % NW, 1, "R1");

    // R2 / R3 / R4: demand fill with words 0 and 1, context 6'b100110.
    fill(2, 6'b100110, 0, 4'b0011, 0, "R2");
    access(2, 0, 9, "R3");
    access(2, 1, 9, "R3");
    access(2, 2, 9, "R4");
    access(2, 3, 9, "R4");
    // R5: record carries context, offset 0 and used 0011; line then empty.
    evict(2, "R5");
    access(2, 0, 9, "R5");
    evict(2, "R9");

    // R2 with another offset, only word 2 used.
    fill(3, 6'b101110, 2, 4'b0100, 0, "R2");
    access(3, 2, 4, "R3");
    access(3, 0, 4, "R4");
    evict(3, "R5");

    // R6: untouched prefetch produces no record.
    fill(5, 0, 0, 4'b1111, 1, "R6");
    access(4, 0, 0, "R6");
    evict(5, "R6");

    // R7: first touch captures context; second touch does not.
    fill(6, 0, 0, 4'b0101, 1, "R7");
    access(6, 2, 6'b101001, "R7");
    access(6, 0, 6'b111111, "R7");
    evict(6, "R7");
    // R7: first touch on an absent word still captures.
    fill(7, 0, 0, 4'b0001, 1, "R7");
    access(7, 3, 6'b010101, "R7");
    evict(7, "R7");

    // R10: refill of a used line clears usage.
    fill(8, 6'b000111, 1, 4'b1111, 0, "R10");
    access(8, 3, 0, "R10");
    fill(8, 6'b111000, 3, 4'b1000, 0, "R10");
    evict(8, "R10");

    // R8: fill, access and evict to one line together.
    fill(9, 6'b110011, 1, 4'b0110, 0, "R8");
    access(9, 1, 0, "R8");
    cyc(1, 9, 6'b001100, 2, 4'b1001, 0, 1, 9, 2, 0, 1, 9, "R8");
    access(9, 0, 0, "R8");
    access(9, 2, 0, "R8");
    evict(9, "R8");
    // R8: access and evict on one line, fill elsewhere.
    fill(10, 6'b010010, 0, 4'b1111, 0, "R8");
    cyc(1, 11, 6'b000001, 0, 4'b0001, 1, 1, 10, 3, 0, 1, 10, "R8");
    access(10, 3, 0, "R8");
    // R8: access to a prefetch line being refilled does not capture.
    cyc(1, 11, 6'b000011, 1, 4'b0011, 1, 1, 11, 0, 6'b111100, 0, 0, "R8");
    evict(11, "R8");

    // Mixed traffic.
    for (int n = 0; n < 400; n++) begin
      cyc($urandom_range(0, 1), $urandom_range(0, 5), $urandom_range(0, 63),
          $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 1),
          $urandom_range(0, 1), $urandom_range(0, 5), $urandom_range(0, 3),
          $urandom_range(0, 63), $urandom_range(0, 1), $urandom_range(0, 5), "R8");
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule